// File: doc/BRIEF.md
# Nonvolatile Memory Command Sequence Guard

This block sits at the front of an on-chip nonvolatile memory controller. It watches every CPU access to the controller's register space and to the memory array. It checks that a command is put together in the only legal order: an aligned word written to an array address, then a known opcode written to the command register, then a launch write to the status register. Any step out of order, any bad width or alignment, and any command aimed at protected storage ends the sequence and raises one of two sticky error flags. Software clears a flag by writing 1 to its bit.

A small timing backend stands in for the program and erase algorithms. It keeps the busy indication asserted for a fixed number of cycles for each opcode. It holds one further command in a single pending slot. A sector-erase-abort command cuts a running sector erase or sector modify short. A stop-mode request kills the running work at once and discards the pending slot.

Register space uses `bus_addr[1:0]`: 0 is the clock divider, 1 is an auxiliary register with no function, 2 is the command register and 3 is the status register. The opcodes are 0x05 erase verify, 0x20 word program, 0x40 sector erase, 0x41 mass erase, 0x47 sector erase abort and 0x60 sector modify.

Top module: `nvm_seq_guard`

## Requirements
- R1: The status byte reads {buf_empty, cmd_idle, prot_err, seq_err, 4'b0} at register 3, and is 0xC0 after reset. A legal three-step sequence launches its command. cmd_idle is then 0 for exactly the opcode's cycle count, counted from the launch edge, and returns to 1. buf_empty stays 1 throughout.
- R2: An array write before any write to the clock divider register (register 0) sets seq_err and starts no sequence.
- R3: An array byte write (bus_word=0), or a word write to an odd address, sets seq_err.
- R4: An array write while a sector-erase-abort is executing sets seq_err.
- R5: After the address step, a write to any register other than the command register, or an opcode outside the six defined ones, sets seq_err and abandons the sequence.
- R6: After the command step, an array write, a second command write, a write to a register other than status, or a status write with bit 7 = 0 sets seq_err. None of these launches a command.
- R7: Reads of any register or of the array never change a flag or the sequence in progress.
- R8: Launching sector-erase-abort when no sector erase or sector modify is running sets seq_err. Launching it during one ends that operation, and cmd_idle returns after the abort's own cycle count.
- R9: A stop request while a command executes or waits sets seq_err. In the next cycle cmd_idle=1 and buf_empty=1. A stop request while idle sets no flag.
- R10: With protection enabled, the check is made when the command register is written. Word program, sector erase or sector modify at an address inside [prot_lo, prot_hi], or any mass erase, sets prot_err and abandons the sequence. Erase verify is never blocked.
- R11: Writing 1 to status bit 4 clears seq_err, and writing 1 to bit 5 clears prot_err. Writing 0 to either bit leaves it unchanged. While either flag is set, array writes are ignored, so no command can be launched.
- R12: A command launched while another executes waits in one pending slot with buf_empty=0. It starts one cycle after the first one finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 1 | 1 = register space, 0 = memory array |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte |
| bus_addr | input | ADDR_W | Byte address (low two bits select the register) |
| bus_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (0 for array reads) |
| prot_en | input | 1 | Protection enable |
| prot_lo | input | ADDR_W | Lowest protected address |
| prot_hi | input | ADDR_W | Highest protected address |
| stop_req | input | 1 | Stop-mode request |
| buf_empty | output | 1 | Command buffer free |
| cmd_idle | output | 1 | No command executing or pending |
| prot_err | output | 1 | Protection violation flag |
| seq_err | output | 1 | Access-order error flag |

## Verification
A sequence state that fails to return to idle after an error shows up on the next launch attempt. Either a command starts although a flag is set, or a legal sequence is refused, and cmd_idle shows this one cycle after the launch write. A wrong pending-slot or backend count shows up as cmd_idle rising on the wrong cycle, so every launch is timed to the exact edge. A missing protection or opcode check raises the wrong flag on the cycle after the command write, visible both on the flag pins and in the status byte.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ADDR, SQ_CMD} seq_state_t;

  localparam logic [7:0] OP_VERIFY = 8'h05;
  localparam logic [7:0] OP_PROG   = 8'h20;
  localparam logic [7:0] OP_SERASE = 8'h40;
  localparam logic [7:0] OP_MERASE = 8'h41;
  localparam logic [7:0] OP_ABORT  = 8'h47;
  localparam logic [7:0] OP_MODIFY = 8'h60;

  localparam logic [1:0] RG_DIV  = 2'd0;
  localparam logic [1:0] RG_AUX  = 2'd1;
  localparam logic [1:0] RG_CMD  = 2'd2;
  localparam logic [1:0] RG_STAT = 2'd3;

  localparam int STB_EMPTY = 7;
  localparam int STB_IDLE  = 6;
  localparam int STB_PERR  = 5;
  localparam int STB_SERR  = 4;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_VERIFY) || (op == OP_PROG) || (op == OP_SERASE) ||
           (op == OP_MERASE) || (op == OP_ABORT) || (op == OP_MODIFY);
  endfunction

  function automatic logic op_ranged(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_SERASE) || (op == OP_MODIFY);
  endfunction

  function automatic logic op_cuttable(input logic [7:0] op);
    return (op == OP_SERASE) || (op == OP_MODIFY);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nvm_prot_check.sv
module nvm_prot_check
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        op,
  output logic              viol
);
  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] l,
                                     input logic [ADDR_W-1:0] h);
    return (a >= l) && (a <= h);
  endfunction

  always_comb begin
    viol = 1'b0;
    if (en) begin
      if (op == OP_MERASE) viol = 1'b1;
      else if (op_ranged(op) && in_window(addr, lo, hi)) viol = 1'b1;
    end
  end
endmodule

// File: rtl/nvm_seq_fsm.sv
module nvm_seq_fsm
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic              bus_reg,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              start_block,
  input  logic              div_ok,
  input  logic              abort_active,
  input  logic              prot_viol,
  input  logic              stop_req,
  output seq_state_t        state,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [7:0]        seq_op,
  output logic              ev_acc,
  output logic              ev_prot,
  output logic              ev_launch
);
  logic       arr_wr, reg_wr, addr_bad;
  logic [1:0] rsel;
  seq_state_t nstate;
  logic       take_addr, take_op;

  assign arr_wr   = bus_valid && bus_wr && !bus_reg;
  assign reg_wr   = bus_valid && bus_wr && bus_reg;
  assign rsel     = bus_addr[1:0];
  assign addr_bad = !div_ok || !bus_word || bus_addr[0] || abort_active;

  always_comb begin
    nstate    = state;
    ev_acc    = 1'b0;
    ev_prot   = 1'b0;
    ev_launch = 1'b0;
    take_addr = 1'b0;
    take_op   = 1'b0;
    if (stop_req) begin
      nstate = SQ_IDLE;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (arr_wr && !start_block) begin
            if (addr_bad) ev_acc = 1'b1;
            else begin
              take_addr = 1'b1;
              nstate    = SQ_ADDR;
            end
          end
        end
        SQ_ADDR: begin
          if (arr_wr) begin
            if (addr_bad) begin
              ev_acc = 1'b1;
              nstate = SQ_IDLE;
            end else take_addr = 1'b1;
          end else if (reg_wr) begin
            nstate = SQ_IDLE;
            if (rsel != RG_CMD || !op_known(bus_wdata)) ev_acc = 1'b1;
            else if (prot_viol) ev_prot = 1'b1;
            else begin
              take_op = 1'b1;
              nstate  = SQ_CMD;
            end
          end
        end
        SQ_CMD: begin
          if (arr_wr) begin
            ev_acc = 1'b1;
            nstate = SQ_IDLE;
          end else if (reg_wr) begin
            nstate = SQ_IDLE;
            if (rsel == RG_STAT && bus_wdata[STB_EMPTY]) ev_launch = 1'b1;
            else ev_acc = 1'b1;
          end
        end
        default: nstate = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      seq_addr <= '0;
      seq_op   <= '0;
    end else begin
      state <= nstate;
      if (take_addr) seq_addr <= bus_addr;
      if (take_op)   seq_op   <= bus_wdata;
    end
  end
endmodule

// File: rtl/nvm_exec_timer.sv
module nvm_exec_timer
  import nvm_seq_pkg::*;
#(
  parameter int T_VERIFY = 4,
  parameter int T_PROG   = 8,
  parameter int T_SERASE = 16,
  parameter int T_MERASE = 24,
  parameter int T_ABORT  = 3,
  parameter int T_MODIFY = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] start_op,
  input  logic       kill,
  output logic       busy,
  output logic [7:0] run_op
);
  localparam int T_MAX = imax(imax(imax(T_VERIFY, T_PROG), imax(T_SERASE, T_MERASE)),
                              imax(T_ABORT, T_MODIFY));
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] load_val(input logic [7:0] op);
    case (op)
      OP_PROG:   return CNT_W'(T_PROG - 1);
      OP_SERASE: return CNT_W'(T_SERASE - 1);
      OP_MERASE: return CNT_W'(T_MERASE - 1);
      OP_ABORT:  return CNT_W'(T_ABORT - 1);
      OP_MODIFY: return CNT_W'(T_MODIFY - 1);
      default:   return CNT_W'(T_VERIFY - 1);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      run_op <= '0;
    end else if (kill) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= load_val(start_op);
      run_op <= start_op;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/nvm_seq_guard.sv
module nvm_seq_guard
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int T_VERIFY = 4,
  parameter int T_PROG   = 8,
  parameter int T_SERASE = 16,
  parameter int T_MERASE = 24,
  parameter int T_ABORT  = 3,
  parameter int T_MODIFY = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_wr,
  input  logic              bus_reg,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  input  logic              prot_en,
  input  logic [ADDR_W-1:0] prot_lo,
  input  logic [ADDR_W-1:0] prot_hi,
  input  logic              stop_req,
  output logic              buf_empty,
  output logic              cmd_idle,
  output logic              prot_err,
  output logic              seq_err
);
  logic [7:0]        div_q, seq_op, be_op, pend_op, start_op, status;
  logic              div_ok, pend_v, be_busy, start, prot_viol;
  logic              ev_acc, ev_prot, ev_launch;
  logic              stat_wr, clr_s, clr_p, abort_ok, abort_bad, stop_err;
  logic              abort_active, seq_idle;
  logic [ADDR_W-1:0] seq_addr;
  seq_state_t        seq_st;

  assign abort_active = be_busy && (be_op == OP_ABORT);
  assign seq_idle     = (seq_st == SQ_IDLE);

  nvm_prot_check #(.ADDR_W(ADDR_W)) u_prot (
    .en(prot_en), .lo(prot_lo), .hi(prot_hi),
    .addr(seq_addr), .op(bus_wdata), .viol(prot_viol)
  );

  nvm_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_wr(bus_wr), .bus_reg(bus_reg),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .start_block(seq_err || prot_err || pend_v), .div_ok(div_ok),
    .abort_active(abort_active), .prot_viol(prot_viol), .stop_req(stop_req),
    .state(seq_st), .seq_addr(seq_addr), .seq_op(seq_op),
    .ev_acc(ev_acc), .ev_prot(ev_prot), .ev_launch(ev_launch)
  );

  nvm_exec_timer #(
    .T_VERIFY(T_VERIFY), .T_PROG(T_PROG), .T_SERASE(T_SERASE),
    .T_MERASE(T_MERASE), .T_ABORT(T_ABORT), .T_MODIFY(T_MODIFY)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
    .kill(stop_req), .busy(be_busy), .run_op(be_op)
  );

  // launch routing: abort cuts a running erase/modify, others queue or start
  assign abort_ok  = ev_launch && (seq_op == OP_ABORT) && be_busy && op_cuttable(be_op);
  assign abort_bad = ev_launch && (seq_op == OP_ABORT) && !abort_ok;
  assign stop_err  = stop_req && (be_busy || pend_v);
  assign start     = !stop_req && ((pend_v && !be_busy) || abort_ok ||
                     (ev_launch && (seq_op != OP_ABORT) && !be_busy));
  assign start_op  = (pend_v && !be_busy) ? pend_op : seq_op;

  assign stat_wr = bus_valid && bus_wr && bus_reg && (bus_addr[1:0] == RG_STAT);
  assign clr_s   = stat_wr && bus_wdata[STB_SERR];
  assign clr_p   = stat_wr && bus_wdata[STB_PERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      div_ok   <= 1'b0;
      seq_err  <= 1'b0;
      prot_err <= 1'b0;
      pend_v   <= 1'b0;
      pend_op  <= '0;
    end else begin
      if (bus_valid && bus_wr && bus_reg && (bus_addr[1:0] == RG_DIV)) begin
        div_q  <= bus_wdata;
        div_ok <= 1'b1;
      end
      seq_err  <= (seq_err && !clr_s) || ev_acc || abort_bad || stop_err;
      prot_err <= (prot_err && !clr_p) || ev_prot;
      if (stop_req) pend_v <= 1'b0;
      else if (pend_v && !be_busy) pend_v <= 1'b0;
      else if (ev_launch && (seq_op != OP_ABORT) && be_busy) begin
        pend_v  <= 1'b1;
        pend_op <= seq_op;
      end
    end
  end

  assign buf_empty = !pend_v;
  assign cmd_idle  = !be_busy && !pend_v;
  assign status    = {buf_empty, cmd_idle, prot_err, seq_err, 4'b0000};

  always_comb begin
    rd_data = '0;
    if (bus_reg) begin
      unique case (bus_addr[1:0])
        RG_DIV:  rd_data = div_q;
        RG_AUX:  rd_data = '0;
        RG_CMD:  rd_data = seq_op;
        RG_STAT: rd_data = status;
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/nvm_seq_guard_chk.sv
module nvm_seq_guard_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_wr,
  input logic              bus_reg,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              stop_req,
  input logic              buf_empty,
  input logic              cmd_idle,
  input logic              prot_err,
  input logic              seq_err,
  input logic              seq_idle,
  input logic              abort_active
);
  logic stat_wr, arr_wr, rd_acc;
  assign stat_wr = bus_valid && bus_wr && bus_reg && (bus_addr[1:0] == 2'd3);
  assign arr_wr  = bus_valid && bus_wr && !bus_reg;
  assign rd_acc  = bus_valid && !bus_wr;

  // R11
  serr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err && !(stat_wr && bus_wdata[4]) |=> seq_err);
  // R11
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err && !(stat_wr && bus_wdata[5]) |=> prot_err);
  // R11
  blocked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err || prot_err) && seq_idle && arr_wr && !stop_req |=> seq_idle);
  // R12
  pend_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_empty |-> !cmd_idle);
  // R9
  stop_purge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && !cmd_idle |=> seq_err && cmd_idle && buf_empty);
  // R7
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && !stop_req |=> $stable(seq_err) && $stable(prot_err));
  // R4
  abort_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_active && arr_wr && seq_idle && !seq_err && !prot_err && buf_empty && !stop_req
    |=> seq_err);
  // R1
  launch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_idle) |-> $past(stat_wr && bus_wdata[7]));
endmodule

bind nvm_seq_guard nvm_seq_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr),
  .bus_reg(bus_reg), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .stop_req(stop_req), .buf_empty(buf_empty), .cmd_idle(cmd_idle),
  .prot_err(prot_err), .seq_err(seq_err), .seq_idle(seq_idle),
  .abort_active(abort_active)
);

// File: tb/test_nvm_seq_guard.sv
module test_nvm_seq_guard;
  localparam int AW = 10;
  localparam int TV = 4, TP = 8, TS = 16, TM = 24, TA = 3, TMD = 20;
  localparam logic [7:0] C_VER = 8'h05, C_PRG = 8'h20, C_SER = 8'h40,
                         C_MER = 8'h41, C_ABT = 8'h47;
  localparam logic [1:0] A_DIV = 2'd0, A_AUX = 2'd1, A_CMD = 2'd2, A_ST = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_wr = 0, bus_reg = 0, bus_word = 0;
  logic [AW-1:0] bus_addr = '0, prot_lo = '0, prot_hi = '0;
  logic [7:0] bus_wdata = '0, rd_data;
  logic prot_en = 0, stop_req = 0;
  logic buf_empty, cmd_idle, prot_err, seq_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nvm_seq_guard #(.ADDR_W(AW), .T_VERIFY(TV), .T_PROG(TP), .T_SERASE(TS),
                  .T_MERASE(TM), .T_ABORT(TA), .T_MODIFY(TMD)) i_nvm_seq_guard (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr),
    .bus_reg(bus_reg), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .prot_en(prot_en),
    .prot_lo(prot_lo), .prot_hi(prot_hi), .stop_req(stop_req),
    .buf_empty(buf_empty), .cmd_idle(cmd_idle), .prot_err(prot_err),
    .seq_err(seq_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic [3:0] exp);
    chk(req, {buf_empty, cmd_idle, prot_err, seq_err}, exp);
  endtask

  task automatic wr_reg(input logic [1:0] r, input logic [7:0] d);
    bus_valid = 1; bus_wr = 1; bus_reg = 1; bus_word = 0;
    bus_addr = AW'(r); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_wr = 0;
  endtask

  task automatic wr_arr(input logic [AW-1:0] a, input logic w);
    bus_valid = 1; bus_wr = 1; bus_reg = 0; bus_word = w;
    bus_addr = a; bus_wdata = 8'h5A;
    @(negedge clk);
    bus_valid = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic isreg, input logic [AW-1:0] a, output logic [7:0] d);
    bus_valid = 1; bus_wr = 0; bus_reg = isreg; bus_word = 1; bus_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic launch(input logic [7:0] op, input logic [AW-1:0] a);
    wr_arr(a, 1'b1);
    wr_reg(A_CMD, op);
    wr_reg(A_ST, 8'h80);
  endtask

  task automatic clear_flags();
    wr_reg(A_ST, 8'h30);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!cmd_idle && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk_flags("R1 reset flags", 4'b1100);
    rd(1'b1, AW'(A_ST), d);
    chk("R1 reset status byte", d, 8'hC0);
  endtask

  task automatic t_div_first();
    logic [7:0] d;
    wr_arr(10'h010, 1'b1);
    chk_flags("R2 array write before divider", 4'b1101);
    rd(1'b1, AW'(A_ST), d);
    chk("R2 status byte", d, 8'hD0);
    clear_flags();
    chk_flags("R11 clear seq_err", 4'b1100);
    wr_reg(A_DIV, 8'h07);
    rd(1'b1, AW'(A_DIV), d);
    chk("R2 divider readback", d, 8'h07);
  endtask

  task automatic t_align();
    wr_arr(10'h011, 1'b1);
    chk_flags("R3 odd word address", 4'b1101);
    clear_flags();
    wr_arr(10'h010, 1'b0);
    chk_flags("R3 byte write", 4'b1101);
    clear_flags();
  endtask

  task automatic t_legal();
    int n;
    launch(C_PRG, 10'h020);
    chk_flags("R1 program started", 4'b1000);
    wait_idle(n);
    chk("R1 program duration", n, TP);
    launch(C_VER, 10'h100);
    wait_idle(n);
    chk("R1 verify duration", n, TV);
    chk_flags("R1 idle after verify", 4'b1100);
  endtask

  task automatic t_addr_step();
    wr_arr(10'h030, 1'b1); wr_reg(A_AUX, 8'h00);
    chk_flags("R5 aux write after address", 4'b1101);
    clear_flags();
    wr_arr(10'h030, 1'b1); wr_reg(A_CMD, 8'h33);
    chk_flags("R5 invalid opcode", 4'b1101);
    clear_flags();
    wr_arr(10'h030, 1'b1); wr_reg(A_DIV, 8'h07);
    chk_flags("R5 divider write after address", 4'b1101);
    clear_flags();
  endtask

  task automatic t_cmd_step();
    for (int k = 0; k < 4; k++) begin
      wr_arr(10'h030, 1'b1);
      wr_reg(A_CMD, C_PRG);
      case (k)
        0: wr_arr(10'h032, 1'b1);
        1: wr_reg(A_CMD, C_PRG);
        2: wr_reg(A_AUX, 8'h00);
        default: wr_reg(A_ST, 8'h00);
      endcase
      @(negedge clk);
      chk_flags($sformatf("R6 case %0d no launch", k), 4'b1101);
      clear_flags();
    end
  endtask

  task automatic t_reads();
    logic [7:0] d;
    int n;
    wr_arr(10'h040, 1'b1);
    rd(1'b1, AW'(A_ST), d);
    chk("R7 status read mid sequence", d, 8'hC0);
    rd(1'b0, 10'h040, d);
    wr_reg(A_CMD, C_PRG);
    rd(1'b1, AW'(A_CMD), d);
    chk("R7 command readback", d, C_PRG);
    wr_reg(A_ST, 8'h80);
    chk_flags("R7 launch after reads", 4'b1000);
    wait_idle(n);
    chk("R7 duration", n, TP);
  endtask

  task automatic t_abort();
    int n;
    launch(C_ABT, 10'h040);
    chk_flags("R8 abort with nothing running", 4'b1101);
    clear_flags();
    launch(C_SER, 10'h040);
    launch(C_ABT, 10'h040);
    chk_flags("R8 abort accepted", 4'b1000);
    wr_arr(10'h050, 1'b1);
    chk_flags("R4 array write during abort", 4'b1001);
    wait_idle(n);
    chk("R8 erase cut short", n, TA - 1);
    clear_flags();
  endtask

  task automatic t_stop();
    stop_req = 1; @(negedge clk); stop_req = 0;
    chk_flags("R9 stop while idle", 4'b1100);
    launch(C_PRG, 10'h020);
    repeat (2) @(negedge clk);
    stop_req = 1; @(negedge clk); stop_req = 0;
    chk_flags("R9 stop kills program", 4'b1101);
    clear_flags();
    launch(C_SER, 10'h040);
    launch(C_PRG, 10'h020);
    chk_flags("R12 second command pending", 4'b0000);
    stop_req = 1; @(negedge clk); stop_req = 0;
    chk_flags("R9 stop drops pending", 4'b1101);
    clear_flags();
  endtask

  task automatic t_prot();
    logic [7:0] d;
    int n;
    prot_en = 1; prot_lo = 10'h100; prot_hi = 10'h1FF;
    wr_arr(10'h120, 1'b1); wr_reg(A_CMD, C_PRG);
    chk_flags("R10 program in window", 4'b1110);
    rd(1'b1, AW'(A_ST), d);
    chk("R10 status byte", d, 8'hE0);
    wr_reg(A_ST, 8'h20);
    launch(C_PRG, 10'h020);
    wait_idle(n);
    chk("R10 program outside window", n, TP);
    wr_arr(10'h020, 1'b1); wr_reg(A_CMD, C_MER);
    chk_flags("R10 mass erase protected", 4'b1110);
    wr_reg(A_ST, 8'h20);
    wr_arr(10'h1FE, 1'b1); wr_reg(A_CMD, C_SER);
    chk_flags("R10 sector erase at top edge", 4'b1110);
    wr_reg(A_ST, 8'h20);
    launch(C_VER, 10'h120);
    wait_idle(n);
    chk("R10 verify not blocked", n, TV);
    prot_en = 0;
    launch(C_MER, 10'h000);
    wait_idle(n);
    chk("R10 mass erase unprotected", n, TM);
  endtask

  task automatic t_block();
    wr_arr(10'h011, 1'b1);
    wr_reg(A_ST, 8'h00);
    chk_flags("R11 writing 0 keeps flag", 4'b1101);
    launch(C_PRG, 10'h020);
    @(negedge clk);
    chk_flags("R11 no launch while flagged", 4'b1101);
    wr_reg(A_ST, 8'h10);
    chk_flags("R11 bit 4 clears", 4'b1100);
  endtask

  task automatic t_pend();
    int n;
    launch(C_SER, 10'h040);
    launch(C_PRG, 10'h020);
    chk_flags("R12 pending slot full", 4'b0000);
    wait_idle(n);
    chk("R12 back-to-back duration", n, TS + TP - 2);
    chk_flags("R12 all done", 4'b1100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_div_first();
    t_align();
    t_legal();
    t_addr_step();
    t_cmd_step();
    t_reads();
    t_abort();
    t_stop();
    t_prot();
    t_block();
    t_pend();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule